// File: doc/BRIEF.md
# SPI-3 Link Receive Demultiplexer

This block sits on the link-layer side of one SPI-3 receive interface. It samples the PHY's 32-bit data bus and its qualifiers on the rising edge of the receive clock. It takes the in-band port address from address cycles. It then forwards each data word to a shared downstream queue memory as one write. Each write carries the data, start and end markers, per-byte valid bits derived from the word modulo, the error flag and a port tag. The tag holds the port number in its low bits and this interface's number (a parameter) in the bits directly above. This lets up to four receive links feed one set of downstream queues without their port numbers colliding.

Flow control uses a FIFO-full threshold input from the memory, nominally set at three-quarters full. While a port is selected and that input is high, the block raises the enable output so the PHY pauses. A word counts only when the data-valid input is high and the enable output was low at the previous clock edge. Parity over the data bus is checked against an even/odd mode input, and any mismatch sets a sticky flag.

The control is a three-state machine. NOPORT is the state after reset, with no port captured. It moves to RUN on an accepted address cycle. RUN moves to HOLD when the FIFO-full input is high. HOLD returns to RUN when that input falls. An address cycle in RUN or HOLD changes the selected port and does not change the state. The enable output is high only in HOLD.

Top module: `spi3_rx_demux`

## Requirements
- R1: During reset and afterwards until a port is captured and the FIFO is full, rx_enb, wr_en and perr_flag are low. No input cycle is accepted at the first clock edge after reset is released.
- R2: A data word is accepted at a rising edge where rx_val is high and rx_enb was low at the previous rising edge. An accepted word with a port selected appears with wr_en high in the following cycle. No other cycle produces a write.
- R3: An address cycle is one with rx_val low, rx_sx high and rx_enb low at the previous edge. It selects port rx_dat[PORT_W-1:0], and the higher bits of rx_dat are ignored. A cycle with rx_sx high and rx_val high is a data word and does not change the selected port.
- R4: Data words accepted before any address cycle since reset are dropped and produce no write.
- R5: wr_tag carries the selected port in bits [PORT_W-1:0] and the parameter IF_NUM in the next IF_W bits. With the defaults, bits [1:0] hold the port and bits [3:2] hold the interface number.
- R6: An address cycle in the middle of a packet switches the tag of all following words to the new port. Returning to an earlier port resumes its tag.
- R7: wr_data, wr_sop, wr_eop and wr_err equal rx_dat, rx_sop, rx_eop and rx_err of the accepted word.
- R8: Lane b of wr_bv covers bits [8b+7:8b]. When rx_eop is high, lane b is valid only if b >= rx_mod, so rx_mod counts the invalid low-order bytes. A word without rx_eop has wr_bv = 4'b1111.
- R9: With a port selected, fifo_full high makes rx_enb high from the next cycle. A word presented while rx_enb was high at the previous edge is not written. rx_enb falls the cycle after fifo_full goes low.
- R10: With par_odd = 1 the count of ones in rx_dat plus rx_par must be odd, and with par_odd = 0 it must be even. The check applies to every accepted data or address cycle. A mismatch sets perr_flag in the next cycle.
- R11: perr_flag stays set until a perr_clr pulse clears it. A new mismatch in the same cycle as perr_clr keeps the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, all inputs sampled on rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_dat | input | DATA_W | Receive data bus; port address on address cycles |
| rx_val | input | 1 | Data-valid qualifier |
| rx_sx | input | 1 | Address-cycle marker, meaningful when rx_val is low |
| rx_sop | input | 1 | Start of packet |
| rx_eop | input | 1 | End of packet |
| rx_err | input | 1 | Packet ended in error, given with rx_eop |
| rx_mod | input | MOD_W | Count of invalid low bytes on the end word |
| rx_par | input | 1 | Parity bit over rx_dat |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| fifo_full | input | 1 | Downstream queue above its threshold |
| perr_clr | input | 1 | Read-clear pulse for the parity flag |
| rx_enb | output | 1 | Enable to PHY, high requests a pause |
| wr_en | output | 1 | Queue write strobe |
| wr_data | output | DATA_W | Write data |
| wr_sop | output | 1 | Start marker to queue |
| wr_eop | output | 1 | End marker to queue |
| wr_bv | output | BYTES | Per-byte valid bits |
| wr_err | output | 1 | Error marker to queue |
| wr_tag | output | PORT_W+IF_W | Interface number and port tag |
| perr_flag | output | 1 | Sticky parity error |

## Verification
The assertions take for granted that the PHY does not change rx_sx or rx_dat in a way the enable rule forbids. They also take for granted that fifo_full only has meaning once a port has been captured. The pause and write-qualification properties therefore reason only from rx_enb history and fifo_full. The stimulus drives every input at the falling edge. It pairs rx_sx with rx_val low for real address cycles, except for one deliberate rx_sx-with-rx_val case. It raises fifo_full only after a port is selected and waits out the two-edge enable latency before it treats the link as paused or resumed. Parity bits are generated from the chosen mode, except for words that are made bad on purpose.

// File: rtl/spi3_rx_pkg.sv
package spi3_rx_pkg;

    typedef enum logic [1:0] {
        ST_NOPORT = 2'd0,
        ST_RUN    = 2'd1,
        ST_HOLD   = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic sop;
        logic eop;
        logic err;
    } rx_flags_t;

endpackage

// File: rtl/spi3_rx_ctrl.sv
module spi3_rx_ctrl
    import spi3_rx_pkg::*;
#(
    parameter int PORT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_val,
    input  logic              rx_sx,
    input  logic              fifo_full,
    input  logic [PORT_W-1:0] port_in,
    output logic              rx_enb,
    output logic              wr_go,
    output logic              chk_go,
    output logic [PORT_W-1:0] cur_port
);

    rx_state_e state_q, state_d;
    logic      enb_prev_q;
    logic      acc_data, acc_addr;

    assign acc_data = rx_val & ~enb_prev_q;
    assign acc_addr = ~rx_val & rx_sx & ~enb_prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_NOPORT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NOPORT: if (acc_addr)   state_d = ST_RUN;
            ST_RUN:    if (fifo_full)  state_d = ST_HOLD;
            ST_HOLD:   if (!fifo_full) state_d = ST_RUN;
            default:                   state_d = ST_NOPORT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enb_prev_q <= 1'b1;
            cur_port   <= '0;
        end else begin
            enb_prev_q <= rx_enb;
            if (acc_addr) cur_port <= port_in;
        end
    end

    always_comb begin
        rx_enb = (state_q == ST_HOLD);
        wr_go  = acc_data && (state_q != ST_NOPORT);
        chk_go = acc_data | acc_addr;
    end

    AST_PAUSE_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_NOPORT && fifo_full) |=> rx_enb); // R9
    AST_RESUME_ON_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !fifo_full) |=> !rx_enb); // R9
    AST_NOPORT_NO_ENB: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NOPORT && !acc_addr) |=> !rx_enb); // R1

endmodule

// File: rtl/spi3_rx_parity.sv
module spi3_rx_parity #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_go,
    input  logic [DATA_W-1:0] dat,
    input  logic              par,
    input  logic              odd_sel,
    input  logic              clr,
    output logic              err_flag
);

    logic mismatch;

    assign mismatch = ((^dat) ^ par) != odd_sel;

    always_ff @(posedge clk) begin
        if (!rst_n)                   err_flag <= 1'b0;
        else if (chk_go && mismatch)  err_flag <= 1'b1;
        else if (clr)                 err_flag <= 1'b0;
    end

    AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !clr) |=> err_flag); // R11
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_go && mismatch) |=> err_flag); // R10

endmodule

// File: rtl/spi3_rx_wrfmt.sv
module spi3_rx_wrfmt
    import spi3_rx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PORT_W = 2,
    parameter int IF_W   = 2,
    parameter int IF_NUM = 2,
    localparam int BYTES = DATA_W / 8,
    localparam int MOD_W = (BYTES > 1) ? $clog2(BYTES) : 1,
    localparam int TAG_W = PORT_W + IF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [DATA_W-1:0] dat,
    input  rx_flags_t         flags,
    input  logic [MOD_W-1:0]  mod,
    input  logic [PORT_W-1:0] port,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_sop,
    output logic              wr_eop,
    output logic [BYTES-1:0]  wr_bv,
    output logic              wr_err,
    output logic [TAG_W-1:0]  wr_tag
);

    logic [BYTES-1:0] bv_d;
    logic [TAG_W-1:0] tag_d;

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        assign bv_d[b] = !flags.eop || (b >= int'(mod));
    end

    if (IF_W > 0) begin : g_ext_tag
        localparam logic [IF_W-1:0] IF_TAG = IF_W'(IF_NUM);
        assign tag_d = {IF_TAG, port};
    end else begin : g_plain_tag
        assign tag_d = port;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en <= 1'b0;
        end else begin
            wr_en <= go;
        end
    end

    always_ff @(posedge clk) begin
        if (go) begin
            wr_data <= dat;
            wr_sop  <= flags.sop;
            wr_eop  <= flags.eop;
            wr_err  <= flags.err;
            wr_bv   <= bv_d;
            wr_tag  <= tag_d;
        end
    end

endmodule

// File: rtl/spi3_rx_demux.sv
module spi3_rx_demux
    import spi3_rx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PORT_W = 2,
    parameter int IF_W   = 2,
    parameter int IF_NUM = 2,
    localparam int BYTES = DATA_W / 8,
    localparam int MOD_W = (BYTES > 1) ? $clog2(BYTES) : 1,
    localparam int TAG_W = PORT_W + IF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] rx_dat,
    input  logic              rx_val,
    input  logic              rx_sx,
    input  logic              rx_sop,
    input  logic              rx_eop,
    input  logic              rx_err,
    input  logic [MOD_W-1:0]  rx_mod,
    input  logic              rx_par,
    input  logic              par_odd,
    input  logic              fifo_full,
    input  logic              perr_clr,
    output logic              rx_enb,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_sop,
    output logic              wr_eop,
    output logic [BYTES-1:0]  wr_bv,
    output logic              wr_err,
    output logic [TAG_W-1:0]  wr_tag,
    output logic              perr_flag
);

    logic              wr_go, chk_go;
    logic [PORT_W-1:0] cur_port;
    rx_flags_t         flags;

    assign flags = '{sop: rx_sop, eop: rx_eop, err: rx_err};

    spi3_rx_ctrl #(.PORT_W(PORT_W)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_val   (rx_val),
        .rx_sx    (rx_sx),
        .fifo_full(fifo_full),
        .port_in  (rx_dat[PORT_W-1:0]),
        .rx_enb   (rx_enb),
        .wr_go    (wr_go),
        .chk_go   (chk_go),
        .cur_port (cur_port)
    );

    spi3_rx_parity #(.DATA_W(DATA_W)) par_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .chk_go  (chk_go),
        .dat     (rx_dat),
        .par     (rx_par),
        .odd_sel (par_odd),
        .clr     (perr_clr),
        .err_flag(perr_flag)
    );

    spi3_rx_wrfmt #(
        .DATA_W(DATA_W), .PORT_W(PORT_W), .IF_W(IF_W), .IF_NUM(IF_NUM)
    ) fmt_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (wr_go),
        .dat    (rx_dat),
        .flags  (flags),
        .mod    (rx_mod),
        .port   (cur_port),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .wr_sop (wr_sop),
        .wr_eop (wr_eop),
        .wr_bv  (wr_bv),
        .wr_err (wr_err),
        .wr_tag (wr_tag)
    );

    AST_WR_NEEDS_ENB_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !$past(rx_enb, 2)); // R2
    AST_WR_NEEDS_VAL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(rx_val)); // R2
    AST_MID_WORD_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_eop) |-> (&wr_bv)); // R8

endmodule

// File: tb/spi3_rx_demux_tb_top.sv
module spi3_rx_demux_tb_top;

    localparam int IFN = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] rx_dat = '0;
    logic        rx_val = 1'b0, rx_sx = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0;
    logic        rx_err = 1'b0, rx_par = 1'b0, par_odd = 1'b0;
    logic [1:0]  rx_mod = '0;
    logic        fifo_full = 1'b0, perr_clr = 1'b0;
    logic        rx_enb, wr_en, wr_sop, wr_eop, wr_err, perr_flag;
    logic [31:0] wr_data;
    logic [3:0]  wr_bv, wr_tag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] d;
        logic        sop, eop, err;
        logic [3:0]  bv, tag;
        string       req;
    } exp_t;
    exp_t sb_q[$];

    spi3_rx_demux dut_i (
        .clk(clk), .rst_n(rst_n), .rx_dat(rx_dat), .rx_val(rx_val), .rx_sx(rx_sx),
        .rx_sop(rx_sop), .rx_eop(rx_eop), .rx_err(rx_err), .rx_mod(rx_mod),
        .rx_par(rx_par), .par_odd(par_odd), .fifo_full(fifo_full), .perr_clr(perr_clr),
        .rx_enb(rx_enb), .wr_en(wr_en), .wr_data(wr_data), .wr_sop(wr_sop),
        .wr_eop(wr_eop), .wr_bv(wr_bv), .wr_err(wr_err), .wr_tag(wr_tag),
        .perr_flag(perr_flag)
    );

    always #10 clk = ~clk;

    function automatic logic pgen(input logic [31:0] d, input logic odd);
        return odd ? ~(^d) : (^d);
    endfunction

    function automatic logic [3:0] bv_of(input logic eop, input logic [1:0] m);
        if (!eop) return 4'hF;
        case (m)
            2'd0: return 4'hF;
            2'd1: return 4'hE;
            2'd2: return 4'hC;
            default: return 4'h8;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_val = 1'b0; rx_sx = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0;
            rx_err = 1'b0; rx_mod = '0; rx_dat = '0; rx_par = pgen('0, par_odd);
        end
    endtask

    task automatic send_addr(input logic [7:0] pbyte, input logic good);
        @(negedge clk);
        rx_val = 1'b0; rx_sx = 1'b1; rx_sop = 1'b0; rx_eop = 1'b0; rx_err = 1'b0;
        rx_mod = '0; rx_dat = {24'h0, pbyte};
        rx_par = good ? pgen(rx_dat, par_odd) : ~pgen(rx_dat, par_odd);
    endtask

    task automatic send_data(input logic [31:0] d, input logic sop, input logic eop,
                             input logic [1:0] m, input logic err, input logic sx,
                             input logic good, input logic expect_wr,
                             input logic [1:0] port, input string req);
        exp_t e;
        @(negedge clk);
        rx_val = 1'b1; rx_sx = sx; rx_sop = sop; rx_eop = eop; rx_err = err;
        rx_mod = m; rx_dat = d;
        rx_par = good ? pgen(d, par_odd) : ~pgen(d, par_odd);
        if (expect_wr) begin
            e.d = d; e.sop = sop; e.eop = eop; e.err = err;
            e.bv = bv_of(eop, m); e.tag = {IFN[1:0], port}; e.req = req;
            sb_q.push_back(e);
        end
    endtask

    // monitor: compare each write against the scoreboard
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            if (sb_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R2 R4 R9 unexpected write actual=%0h expected=none", wr_data);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check({e.req, " R7 data"}, wr_data, e.d);
                check({e.req, " R7 flags"}, {29'h0, wr_sop, wr_eop, wr_err}, {29'h0, e.sop, e.eop, e.err});
                check({e.req, " R8 bv"}, {28'h0, wr_bv}, {28'h0, e.bv});
                check({e.req, " R5 tag"}, {28'h0, wr_tag}, {28'h0, e.tag});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1 enb in reset", {31'h0, rx_enb}, 32'h0);
        check("R1 wr_en in reset", {31'h0, wr_en}, 32'h0);
        check("R1 perr in reset", {31'h0, perr_flag}, 32'h0);
        // address at first edge after release must be ignored (R1)
        rst_n = 1'b1;
        rx_val = 1'b0; rx_sx = 1'b1; rx_dat = 32'h1; rx_par = pgen(32'h1, 1'b0);
        idle(2);
        // no port yet: data dropped (R4)
        send_data(32'hDEAD0001, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, "R4");
        idle(2);
        check("R1 R9 enb low without port", {31'h0, rx_enb}, 32'h0);

        // capture port 2 with junk upper bits (R3), packet (R2 R5 R7 R8)
        send_addr(8'hFE, 1'b1);
        send_data(32'h11223344, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd2, "R3 R2");
        send_data(32'h55667788, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 2'd2, "R8 mid");
        // rx_sx with rx_val high is data, not an address (R3)
        send_data(32'h00000001, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd2, "R3 sx-with-val");
        // mid-packet switch to port 1 and back (R6)
        send_addr(8'h01, 1'b1);
        send_data(32'hA0A0A0A0, 1'b1, 1'b1, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 2'd1, "R6 switch");
        send_addr(8'h02, 1'b1);
        send_data(32'h99AABBCC, 1'b0, 1'b1, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 2'd2, "R6 back R7 err");
        idle(1);
        send_addr(8'h03, 1'b1);
        send_data(32'h0BADF00D, 1'b1, 1'b1, 2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 2'd3, "R8 mod3");
        send_data(32'h12345678, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd3, "R8 mod0");
        idle(2);
        check("R10 no parity error on good words", {31'h0, perr_flag}, 32'h0);

        // pause (R9): in-flight word accepted, later words ignored
        fifo_full = 1'b1;
        send_data(32'hC0FFEE00, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd3, "R9 in-flight");
        send_data(32'hC0FFEE01, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd3, "R9 paused");
        check("R9 enb high while full", {31'h0, rx_enb}, 32'h1);
        send_addr(8'h00, 1'b1);   // ignored too: tag must stay port 3
        send_data(32'hC0FFEE02, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd3, "R9 paused");
        idle(1);
        fifo_full = 1'b0;
        idle(1);
        check("R9 enb low after room", {31'h0, rx_enb}, 32'h0);
        idle(1);
        send_data(32'hC0FFEE03, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 2'd3, "R9 resume");
        idle(2);

        // parity even mode error, sticky, clear (R10 R11)
        send_data(32'h00000003, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd3, "R10 bad even");
        idle(1);
        check("R10 even mismatch sets flag", {31'h0, perr_flag}, 32'h1);
        idle(3);
        check("R11 flag sticky", {31'h0, perr_flag}, 32'h1);
        @(negedge clk); perr_clr = 1'b1;
        @(negedge clk); perr_clr = 1'b0;
        check("R11 cleared by pulse", {31'h0, perr_flag}, 32'h0);
        // odd mode: good word no error, bad address word sets flag
        par_odd = 1'b1;
        send_data(32'h00000007, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd3, "R10 good odd");
        idle(1);
        check("R10 odd good parity", {31'h0, perr_flag}, 32'h0);
        perr_clr = 1'b1;
        send_addr(8'h03, 1'b0);
        idle(1);
        perr_clr = 1'b0;
        check("R10 R11 address mismatch wins over clear", {31'h0, perr_flag}, 32'h1);
        idle(4);
        check("R2 all expected writes seen", sb_q.size(), 32'h0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule